// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block sits on the bus side of a processor core and reads the instruction stream ahead of the execution side. It keeps a code segment value and a 16-bit offset as its fetch pointer, forms a 20-bit physical address from them, and issues bus reads on its own whenever the byte queue has room. Returned bytes, opcodes and immediates alike, go into a six-entry byte queue. The consumer drains them one byte per cycle through a valid/ready handshake.

A control transfer is signalled by a one-cycle flush pulse that carries the new segment and offset. The pulse empties the queue and reloads the fetch pointer, so fetching resumes at the target. If a read is still outstanding when the pulse arrives, its data is thrown away when it returns. The bus side is a simple request/grant scheme with one read in flight at a time. Each read is either a two-byte word from an even address or a single byte from an odd address.

Top module: `ifq_prefetch_unit`

## Requirements
- R1: After reset the queue is empty (q_valid_o low), and a request is presented at address (0xFFFF << 4) + 0x0000 = 0xFFFF0 with bus_wide_o high.
- R2: The request address is (segment << 4) + offset, keeping only the low 20 bits. For example, segment 0xFFFF with offset 0xFFFE gives 0x0FFEE.
- R3: bus_wide_o is high (two-byte read) when the offset is even and low (one-byte read) when the offset is odd.
- R4: A request is raised only while no read is outstanding and at least 2 queue entries are free. Once a request has been granted, bus_req_o stays low until that read's data returns.
- R5: The address holds steady until the request is granted. A grant advances the offset by 2 for a word read or by 1 for a byte read, and the offset wraps from 0xFFFF to 0x0000 within the segment.
- R6: Returned data is queued in address order. A word read enqueues bus_rdata_i[7:0] and then bus_rdata_i[15:8]. A byte read enqueues only bus_rdata_i[7:0] and ignores the upper byte.
- R7: The queue never holds more than 6 bytes. With 5 or 6 bytes queued, no request is raised.
- R8: A byte is removed in every cycle where q_valid_o and q_ready_i are both high. A removal and an arriving read in the same cycle both take effect.
- R9: In the cycle after a flush pulse, the queue is empty and the request address is the flush target.
- R10: Data from a read that was outstanding at a flush is dropped. No new request is raised until that read has returned.
- R11: bus_req_o is low in any cycle where flush_i is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Control-transfer pulse: discard the queue and reload the pointer |
| flush_seg_i | input | 16 | Target code segment, sampled with flush_i |
| flush_off_i | input | 16 | Target offset, sampled with flush_i |
| bus_req_o | output | 1 | Read request |
| bus_addr_o | output | 20 | Physical byte address of the request |
| bus_wide_o | output | 1 | 1 = two-byte read, 0 = one-byte read |
| bus_gnt_i | input | 1 | Grant; the request is accepted when bus_req_o and bus_gnt_i are both high |
| bus_rvld_i | input | 1 | Read data valid, one cycle per read |
| bus_rdata_i | input | 16 | Read data, low byte at the lower address |
| q_valid_o | output | 1 | Queue head byte is valid |
| q_data_o | output | 8 | Queue head byte |
| q_ready_i | input | 1 | Consumer takes the head byte |

## Verification
A fill level or pointer that drifts shows up at the ports within one or two fetches. A lost or duplicated byte surfaces as a wrong value on q_data_o at the next pop. A fill level that is off by one moves the point where bus_req_o drops by one byte, which the bench probes at exactly 4, 5 and 6 queued bytes. A discard flag that is wrong either lets stale data become valid in the cycle after the dropped read returns, or blocks the refetch. A fetch pointer that steps wrongly produces a wrong bus_addr_o on the very next request.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [0:0] {
      BUS_IDLE = 1'b0,
      BUS_WAIT = 1'b1
   } bus_state_e;

endpackage

// File: rtl/ifq_fetch_ptr.sv
module ifq_fetch_ptr #(
   parameter int               SEG_W      = 16,
   parameter int               OFF_W      = 16,
   parameter int               ADDR_W     = 20,
   parameter int               SEG_SHIFT  = 4,
   parameter logic [SEG_W-1:0] RESET_SEG  = '1,
   parameter logic [OFF_W-1:0] RESET_OFF  = '0,
   parameter bit               WIDE_FETCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [SEG_W-1:0]  load_seg_i,
   input  logic [OFF_W-1:0]  load_off_i,
   input  logic              advance_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wide_o
);

   localparam int SEG_SPAN = SEG_W + SEG_SHIFT;
   localparam int SUM_W    = ((SEG_SPAN > OFF_W) ? SEG_SPAN : OFF_W) + 1;

   logic [SEG_W-1:0] seg_q;
   logic [OFF_W-1:0] off_q;
   logic [OFF_W-1:0] step;
   logic [SUM_W-1:0] seg_ext;
   logic [SUM_W-1:0] off_ext;
   logic [SUM_W-1:0] lin_sum;

   always_comb begin
      seg_ext = SUM_W'(seg_q) << SEG_SHIFT;
      off_ext = SUM_W'(off_q);
      lin_sum = seg_ext + off_ext;
   end

   assign addr_o = lin_sum[ADDR_W-1:0];

   if (WIDE_FETCH) begin : g_wide
      assign wide_o = ~off_q[0];
   end else begin : g_narrow
      assign wide_o = 1'b0;
   end

   assign step = wide_o ? OFF_W'(2) : OFF_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q <= RESET_SEG;
         off_q <= RESET_OFF;
      end else if (load_i) begin
         seg_q <= load_seg_i;
         off_q <= load_off_i;
      end else if (advance_i) begin
         off_q <= off_q + step;
      end
   end

endmodule

// File: rtl/ifq_bus_ctrl.sv
module ifq_bus_ctrl
   import ifq_pkg::*;
#(
   parameter int DEPTH = 6,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic [CNT_W-1:0] level_i,
   input  logic             wide_i,
   input  logic             bus_gnt_i,
   input  logic             bus_rvld_i,
   output logic             bus_req_o,
   output logic             advance_o,
   output logic             fill_o,
   output logic             fill_two_o
);

   localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(DEPTH - 2);

   bus_state_e state_q;
   bus_state_e state_d;
   logic       discard_q;
   logic       discard_d;
   logic       pend_two_q;
   logic       room_ok;

   assign room_ok    = (level_i <= ROOM_LIMIT);
   assign bus_req_o  = (state_q == BUS_IDLE) && room_ok && !flush_i;
   assign advance_o  = bus_req_o && bus_gnt_i;
   assign fill_o     = (state_q == BUS_WAIT) && bus_rvld_i && !discard_q && !flush_i;
   assign fill_two_o = pend_two_q;

   always_comb begin
      state_d   = state_q;
      discard_d = discard_q;
      case (state_q)
         BUS_IDLE: begin
            if (advance_o) begin
               state_d   = BUS_WAIT;
               discard_d = 1'b0;
            end
         end
         BUS_WAIT: begin
            if (bus_rvld_i) begin
               state_d   = BUS_IDLE;
               discard_d = 1'b0;
            end else if (flush_i) begin
               discard_d = 1'b1;
            end
         end
         default: begin
            state_d   = BUS_IDLE;
            discard_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= BUS_IDLE;
         discard_q  <= 1'b0;
         pend_two_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         discard_q <= discard_d;
         if (advance_o) begin
            pend_two_q <= wide_i;
         end
      end
   end

endmodule

// File: rtl/ifq_byte_queue.sv
module ifq_byte_queue #(
   parameter int  DEPTH  = 6,
   parameter int  BYTE_W = 8,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              push_i,
   input  logic              push_two_i,
   input  logic [BYTE_W-1:0] lo_i,
   input  logic [BYTE_W-1:0] hi_i,
   input  logic              pop_i,
   output logic [BYTE_W-1:0] head_o,
   output logic [CNT_W-1:0]  level_o
);

   logic [PTR_W-1:0]                wr_ptr_q;
   logic [PTR_W-1:0]                rd_ptr_q;
   logic [CNT_W-1:0]                level_q;
   logic [PTR_W-1:0]                wr_ptr_nx1;
   logic [1:0]                      push_cnt;
   logic                            pop_fire;
   logic [DEPTH-1:0][BYTE_W-1:0]    slot_flat;

   function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                                 input logic [1:0] n);
      logic [PTR_W:0] t;
      t = {1'b0, p} + (PTR_W+1)'(n);
      if (t >= (PTR_W+1)'(DEPTH)) begin
         t = t - (PTR_W+1)'(DEPTH);
      end
      return t[PTR_W-1:0];
   endfunction

   assign wr_ptr_nx1 = wrap_add(wr_ptr_q, 2'd1);
   assign push_cnt   = push_i ? (push_two_i ? 2'd2 : 2'd1) : 2'd0;
   assign pop_fire   = pop_i && (level_q != '0);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic              hit_lo;
      logic              hit_hi;
      logic [BYTE_W-1:0] byte_q;

      assign hit_lo = push_i && (wr_ptr_q == PTR_W'(i));
      assign hit_hi = push_i && push_two_i && (wr_ptr_nx1 == PTR_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (hit_lo) begin
            byte_q <= lo_i;
         end else if (hit_hi) begin
            byte_q <= hi_i;
         end
      end

      assign slot_flat[i] = byte_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         level_q  <= '0;
      end else if (flush_i) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         level_q  <= '0;
      end else begin
         wr_ptr_q <= wrap_add(wr_ptr_q, push_cnt);
         rd_ptr_q <= wrap_add(rd_ptr_q, {1'b0, pop_fire});
         level_q  <= level_q + CNT_W'(push_cnt) - CNT_W'(pop_fire);
      end
   end

   assign head_o  = slot_flat[rd_ptr_q];
   assign level_o = level_q;

endmodule

// File: rtl/ifq_prefetch_unit.sv
module ifq_prefetch_unit
   import ifq_pkg::*;
#(
   parameter int               QUEUE_DEPTH = 6,
   parameter int               SEG_W       = 16,
   parameter int               OFF_W       = 16,
   parameter int               ADDR_W      = 20,
   parameter int               SEG_SHIFT   = 4,
   parameter int               BUS_W       = 16,
   parameter logic [SEG_W-1:0] RESET_SEG   = 16'hFFFF,
   parameter logic [OFF_W-1:0] RESET_OFF   = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic [SEG_W-1:0]  flush_seg_i,
   input  logic [OFF_W-1:0]  flush_off_i,
   output logic              bus_req_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_wide_o,
   input  logic              bus_gnt_i,
   input  logic              bus_rvld_i,
   input  logic [BUS_W-1:0]  bus_rdata_i,
   output logic              q_valid_o,
   output logic [BYTE_W-1:0] q_data_o,
   input  logic              q_ready_i
);

   localparam int CNT_W      = $clog2(QUEUE_DEPTH + 1);
   localparam bit WIDE_FETCH = (BUS_W == 2 * BYTE_W);

   if (QUEUE_DEPTH < 2) begin : g_bad_depth
      $error("ifq_prefetch_unit: QUEUE_DEPTH must be at least 2");
   end
   if ((BUS_W != BYTE_W) && (BUS_W != 2 * BYTE_W)) begin : g_bad_bus
      $error("ifq_prefetch_unit: BUS_W must be 8 or 16");
   end
   if (ADDR_W > SEG_W + SEG_SHIFT + 1) begin : g_bad_addr
      $error("ifq_prefetch_unit: ADDR_W wider than the segment sum");
   end

   logic              advance;
   logic              fill_en;
   logic              fill_two;
   logic [CNT_W-1:0]  q_level;
   logic [BYTE_W-1:0] lo_byte;
   logic [BYTE_W-1:0] hi_byte;

   assign lo_byte = bus_rdata_i[BYTE_W-1:0];

   if (WIDE_FETCH) begin : g_hi_wide
      assign hi_byte = bus_rdata_i[BUS_W-1:BYTE_W];
   end else begin : g_hi_narrow
      assign hi_byte = '0;
   end

   ifq_fetch_ptr #(
      .SEG_W      (SEG_W),
      .OFF_W      (OFF_W),
      .ADDR_W     (ADDR_W),
      .SEG_SHIFT  (SEG_SHIFT),
      .RESET_SEG  (RESET_SEG),
      .RESET_OFF  (RESET_OFF),
      .WIDE_FETCH (WIDE_FETCH)
   ) i_fetch_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (flush_i),
      .load_seg_i (flush_seg_i),
      .load_off_i (flush_off_i),
      .advance_i  (advance),
      .addr_o     (bus_addr_o),
      .wide_o     (bus_wide_o)
   );

   ifq_bus_ctrl #(
      .DEPTH (QUEUE_DEPTH),
      .CNT_W (CNT_W)
   ) i_bus_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_i),
      .level_i    (q_level),
      .wide_i     (bus_wide_o),
      .bus_gnt_i  (bus_gnt_i),
      .bus_rvld_i (bus_rvld_i),
      .bus_req_o  (bus_req_o),
      .advance_o  (advance),
      .fill_o     (fill_en),
      .fill_two_o (fill_two)
   );

   ifq_byte_queue #(
      .DEPTH  (QUEUE_DEPTH),
      .BYTE_W (BYTE_W)
   ) i_byte_queue (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_i),
      .push_i     (fill_en),
      .push_two_i (fill_two),
      .lo_i       (lo_byte),
      .hi_i       (hi_byte),
      .pop_i      (q_ready_i),
      .head_o     (q_data_o),
      .level_o    (q_level)
   );

   assign q_valid_o = (q_level != '0);

endmodule

// File: rtl/ifq_prefetch_checker.sv
module ifq_prefetch_checker #(
   parameter int DEPTH  = 6,
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush_i,
   input logic              bus_req_o,
   input logic              bus_gnt_i,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic              bus_wide_o,
   input logic              q_valid_o,
   input logic [CNT_W-1:0]  q_level,
   input logic              fill_en
);

   localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] ROOM_LVL = CNT_W'(DEPTH - 2);

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_gnt_i) |=> !bus_req_o); // R4

   AST_REQ_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o |-> (q_level <= ROOM_LVL)); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      q_level <= FULL_LVL); // R7

   AST_NO_REQ_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> !bus_req_o); // R11

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !q_valid_o); // R9

   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_wide_o) |-> !bus_addr_o[0]); // R3

   AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_gnt_i) |=> (!bus_req_o || $stable(bus_addr_o))); // R5

   AST_FILL_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> q_valid_o); // R6

endmodule

bind ifq_prefetch_unit ifq_prefetch_checker #(
   .DEPTH  (QUEUE_DEPTH),
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) i_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush_i    (flush_i),
   .bus_req_o  (bus_req_o),
   .bus_gnt_i  (bus_gnt_i),
   .bus_addr_o (bus_addr_o),
   .bus_wide_o (bus_wide_o),
   .q_valid_o  (q_valid_o),
   .q_level    (q_level),
   .fill_en    (fill_en)
);

// File: tb/test_ifq_prefetch_unit.sv
module test_ifq_prefetch_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_i = 1'b0;
   logic [15:0] flush_seg_i = '0;
   logic [15:0] flush_off_i = '0;
   logic        bus_req_o;
   logic [19:0] bus_addr_o;
   logic        bus_wide_o;
   logic        bus_gnt_i = 1'b0;
   logic        bus_rvld_i = 1'b0;
   logic [15:0] bus_rdata_i = '0;
   logic        q_valid_o;
   logic [7:0]  q_data_o;
   logic        q_ready_i = 1'b0;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;
   logic [7:0] mdl[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ifq_prefetch_unit i_ifq_prefetch_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (flush_i),
      .flush_seg_i (flush_seg_i),
      .flush_off_i (flush_off_i),
      .bus_req_o   (bus_req_o),
      .bus_addr_o  (bus_addr_o),
      .bus_wide_o  (bus_wide_o),
      .bus_gnt_i   (bus_gnt_i),
      .bus_rvld_i  (bus_rvld_i),
      .bus_rdata_i (bus_rdata_i),
      .q_valid_o   (q_valid_o),
      .q_data_o    (q_data_o),
      .q_ready_i   (q_ready_i)
   );

   function automatic logic [7:0] mem_byte(input logic [19:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h9};
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic check_req(input logic [19:0] addr, input logic wide, input string req);
      check(bus_req_o === 1'b1, {req, " request raised"}, 32'(bus_req_o), 32'd1);
      check(bus_addr_o === addr, {req, " address"}, 32'(bus_addr_o), 32'(addr));
      check(bus_wide_o === wide, {req, " width"}, 32'(bus_wide_o), 32'(wide));
   endtask

   // Grants the pending request, returns data after lat idle cycles.
   task automatic serve(input logic [19:0] addr, input logic wide, input int lat,
                        input string req);
      check_req(addr, wide, req);
      bus_gnt_i = 1'b1;
      @(negedge clk);
      bus_gnt_i = 1'b0;
      repeat (lat) @(negedge clk);
      bus_rvld_i = 1'b1;
      if (wide) begin
         bus_rdata_i = {mem_byte(addr + 20'd1), mem_byte(addr)};
         mdl.push_back(mem_byte(addr));
         mdl.push_back(mem_byte(addr + 20'd1));
      end else begin
         bus_rdata_i = {8'hEE, mem_byte(addr)};
         mdl.push_back(mem_byte(addr));
      end
      @(negedge clk);
      bus_rvld_i = 1'b0;
      #1;
   endtask

   task automatic pop_n(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         q_ready_i = 1'b1;
         #1;
         check(q_valid_o === 1'b1, {req, " head valid"}, 32'(q_valid_o), 32'd1);
         check(q_data_o === mdl[0], {req, " head byte"}, 32'(q_data_o), 32'(mdl[0]));
         void'(mdl.pop_front());
         @(negedge clk);
      end
      q_ready_i = 1'b0;
      #1;
   endtask

   task automatic do_flush(input logic [15:0] seg, input logic [15:0] off);
      flush_i     = 1'b1;
      flush_seg_i = seg;
      flush_off_i = off;
      #1;
      check(bus_req_o === 1'b0, "R11 no request during flush", 32'(bus_req_o), 32'd0);
      @(negedge clk);
      flush_i = 1'b0;
      #1;
      check(q_valid_o === 1'b0, "R9 queue empty after flush", 32'(q_valid_o), 32'd0);
      mdl.delete();
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(q_valid_o === 1'b0, "R1 empty after reset", 32'(q_valid_o), 32'd0);
      check_req(20'hFFFF0, 1'b1, "R1");
   endtask

   task automatic t_fill_to_full();
      serve(20'hFFFF0, 1'b1, 0, "R5");
      serve(20'hFFFF2, 1'b1, 2, "R5");
      serve(20'hFFFF4, 1'b1, 1, "R4");
      check(bus_req_o === 1'b0, "R7 no request at 6 bytes", 32'(bus_req_o), 32'd0);
      pop_n(1, "R6");
      check(bus_req_o === 1'b0, "R7 no request at 5 bytes", 32'(bus_req_o), 32'd0);
      pop_n(1, "R6");
      check_req(20'hFFFF6, 1'b1, "R4 request at 4 bytes");
      pop_n(4, "R6");
      check(q_valid_o === 1'b0, "R8 drained", 32'(q_valid_o), 32'd0);
   endtask

   task automatic t_odd_start();
      do_flush(16'h1234, 16'h0007);
      check_req(20'h12347, 1'b0, "R9 target odd byte R3");
      serve(20'h12347, 1'b0, 1, "R3");
      serve(20'h12348, 1'b1, 0, "R5 after byte");
      pop_n(3, "R6 byte read low lane");
      check(q_valid_o === 1'b0, "R6 exactly three bytes", 32'(q_valid_o), 32'd0);
   endtask

   task automatic t_wrap();
      do_flush(16'hFFFF, 16'hFFFE);
      serve(20'h0FFEE, 1'b1, 0, "R2 address wrap");
      serve(20'hFFFF0, 1'b1, 0, "R5 offset wrap");
      pop_n(4, "R2");
   endtask

   task automatic t_flush_inflight();
      do_flush(16'h2000, 16'h0100);
      check_req(20'h20100, 1'b1, "R9");
      bus_gnt_i = 1'b1;
      @(negedge clk);
      bus_gnt_i = 1'b0;
      #1;
      do_flush(16'h3000, 16'h0010);
      for (int i = 0; i < 3; i++) begin
         check(bus_req_o === 1'b0, "R10 wait for stale read", 32'(bus_req_o), 32'd0);
         @(negedge clk);
         #1;
      end
      bus_rvld_i  = 1'b1;
      bus_rdata_i = 16'hDEAD;
      @(negedge clk);
      bus_rvld_i = 1'b0;
      #1;
      check(q_valid_o === 1'b0, "R10 stale data dropped", 32'(q_valid_o), 32'd0);
      check_req(20'h30010, 1'b1, "R10 refetch at target");
   endtask

   task automatic t_pop_and_fill();
      serve(20'h30010, 1'b1, 0, "R8");
      check_req(20'h30012, 1'b1, "R8");
      bus_gnt_i = 1'b1;
      @(negedge clk);
      bus_gnt_i   = 1'b0;
      bus_rvld_i  = 1'b1;
      bus_rdata_i = {mem_byte(20'h30013), mem_byte(20'h30012)};
      q_ready_i   = 1'b1;
      #1;
      check(q_data_o === mdl[0], "R8 head during pop and fill", 32'(q_data_o), 32'(mdl[0]));
      void'(mdl.pop_front());
      mdl.push_back(mem_byte(20'h30012));
      mdl.push_back(mem_byte(20'h30013));
      @(negedge clk);
      bus_rvld_i = 1'b0;
      q_ready_i  = 1'b0;
      #1;
      pop_n(3, "R8 both took effect");
      check(q_valid_o === 1'b0, "R8 exactly three left", 32'(q_valid_o), 32'd0);
   endtask

   initial begin
      t_reset();
      t_fill_to_full();
      t_odd_start();
      t_wrap();
      t_flush_inflight();
      t_pop_and_fill();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule